// File: doc/BRIEF.md
# Link-Speed Transmit Frame Throttle

This block paces a frame generator whose 64-bit transmit path always runs at 156.25 MHz. The path has no way to tell the far end to slow down, so a slower link is modelled by holding the generator off for longer after each frame. The longer gap makes the average frame rate match the selected link. The block watches two flags from the generator: busy, and native inter-frame idle. It drives a throttled busy flag that the upstream frame source waits on before it offers the next frame.

A frame occupies the cycles in which either generator flag is high. When both flags fall, the throttled flag stays high for the occupancy multiplied by (ratio − 1). The ratio comes from a 3-bit speed code that is latched on the first cycle of each frame. The receive direction does not depend on the setting. A synchronous, active-high reset clears every counter and releases the throttled flag.

Top module: `tx_throttle`

## Requirements
- R1: A synchronous reset clears all state. In the cycle after a clock edge with `rst` high, `busy_out` is low while both generator flags are low, even if a padding interval was running.
- R2: In every cycle in which `gen_busy` or `gen_idle_gap` is high, `busy_out` is high in that same cycle.
- R3: Let N be the number of consecutive cycles with `gen_busy` or `gen_idle_gap` high, starting at a frame's first active cycle. Counting from the first cycle in which both flags are low, `busy_out` stays high for exactly N·(M−1) cycles and is then low. M is 1, 2, 4, 10, 100 and 1000 for `link_speed` codes 000, 001, 010, 011, 100 and 101.
- R4: Codes 110 and 111 behave like 000 (M = 1), so `busy_out` goes low in the same cycle as the generator flags.
- R5: The ratio is taken from `link_speed` on the first active cycle of a frame. Changes later in that frame or during its padding do not alter the padding length.
- R6: Once padding ends, `busy_out` stays low until the next active cycle. A frame that starts in the first cycle after padding is padded in the same way.
- R7: Cycles in which only `gen_idle_gap` is high count toward N in the same way as busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single 156.25 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| link_speed | input | 3 | Speed code, latched at frame start |
| gen_busy | input | 1 | Generator is sending a frame |
| gen_idle_gap | input | 1 | Generator is in its native inter-frame idle |
| busy_out | output | 1 | Throttled busy flag for the frame source |

## Verification
`busy_out` reacts to the generator flags in the same cycle, through combinational logic. The padding is held in registers that load on the first inactive cycle and count down from the next edge. The bench changes inputs on the falling edge and reads `busy_out` one nanosecond later, so every sample reflects that cycle's inputs and the registers from the previous rising edge. After a frame, it counts high samples starting with the first inactive cycle and compares the count with N·(M−1) from its own ratio table. It then checks two further low samples. The reset check samples in the first cycle after the edge at which `rst` was seen.

// File: rtl/tx_throttle_pkg.sv
package tx_throttle_pkg;

    localparam int FACTOR_W = 10;

    typedef enum logic [2:0] {
        RATE_10G   = 3'b000,
        RATE_5G    = 3'b001,
        RATE_2G5   = 3'b010,
        RATE_1G    = 3'b011,
        RATE_100M  = 3'b100,
        RATE_10M   = 3'b101,
        RATE_SPARE6 = 3'b110,
        RATE_SPARE7 = 3'b111
    } link_rate_e;

    typedef struct packed {
        logic active;
        logic start;
        logic done;
    } frame_evt_t;

    // Extra idle cycles owed per occupied cycle (ratio minus one).
    function automatic logic [FACTOR_W-1:0] pad_factor(input logic [2:0] code);
        case (link_rate_e'(code))
            RATE_5G:   return FACTOR_W'(1);
            RATE_2G5:  return FACTOR_W'(3);
            RATE_1G:   return FACTOR_W'(9);
            RATE_100M: return FACTOR_W'(99);
            RATE_10M:  return FACTOR_W'(999);
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/tx_thr_rate_latch.sv
module tx_thr_rate_latch
    import tx_throttle_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic [2:0]          code,
    output logic [FACTOR_W-1:0] factor_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            factor_q <= '0;
        end else if (capture) begin
            factor_q <= pad_factor(code);
        end
    end
endmodule

// File: rtl/tx_thr_occ_counter.sv
module tx_thr_occ_counter #(
    parameter int OCC_W   = 16,
    parameter bit SAT_OCC = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             active,
    output logic [OCC_W-1:0] occ
);
    logic [OCC_W-1:0] occ_next;

    generate
        if (SAT_OCC) begin : g_sat
            always_comb occ_next = (&occ) ? occ : occ + 1'b1;
        end else begin : g_wrap
            always_comb occ_next = occ + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else if (start) begin
            occ <= OCC_W'(1);
        end else if (active) begin
            occ <= occ_next;
        end
    end
endmodule

// File: rtl/tx_thr_pad_timer.sv
module tx_thr_pad_timer #(
    parameter int PAD_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PAD_W-1:0] load_val,
    output logic             pad_active,
    output logic [PAD_W-1:0] pad_rem
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pad_rem <= '0;
        end else if (load) begin
            pad_rem <= load_val;
        end else if (pad_rem != '0) begin
            pad_rem <= pad_rem - 1'b1;
        end
    end

    assign pad_active = (pad_rem != '0);
endmodule

// File: rtl/tx_throttle.sv
module tx_throttle
    import tx_throttle_pkg::*;
#(
    parameter int OCC_W   = 16,
    parameter int PAD_W   = 24,
    parameter bit SAT_OCC = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] link_speed,
    input  logic       gen_busy,
    input  logic       gen_idle_gap,
    output logic       busy_out
);
    localparam int PROD_W = OCC_W + FACTOR_W;

    frame_evt_t          evt;
    logic                in_frame;
    logic [FACTOR_W-1:0] factor_q;
    logic [OCC_W-1:0]    occ;
    logic [PROD_W-1:0]   prod;
    logic [PAD_W-1:0]    extra;
    logic [PAD_W-1:0]    load_val;
    logic                pad_active;
    logic [PAD_W-1:0]    pad_rem;

    always_comb begin
        evt.active = gen_busy | gen_idle_gap;
        evt.start  = !in_frame && evt.active;
        evt.done   = in_frame && !evt.active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
        end else if (evt.start) begin
            in_frame <= 1'b1;
        end else if (evt.done) begin
            in_frame <= 1'b0;
        end
    end

    tx_thr_rate_latch u_rate (
        .clk      (clk),
        .rst      (rst),
        .capture  (evt.start),
        .code     (link_speed),
        .factor_q (factor_q)
    );

    tx_thr_occ_counter #(.OCC_W(OCC_W), .SAT_OCC(SAT_OCC)) u_occ (
        .clk    (clk),
        .rst    (rst),
        .start  (evt.start),
        .active (evt.active),
        .occ    (occ)
    );

    assign prod = PROD_W'(occ) * PROD_W'(factor_q);

    generate
        if (PROD_W > PAD_W) begin : g_clip
            always_comb extra = (|prod[PROD_W-1:PAD_W]) ? {PAD_W{1'b1}} : prod[PAD_W-1:0];
        end else begin : g_widen
            always_comb extra = PAD_W'(prod);
        end
    endgenerate

    // The cycle in which the flags fall already counts as the first padded cycle.
    assign load_val = (extra == '0) ? '0 : extra - 1'b1;

    tx_thr_pad_timer #(.PAD_W(PAD_W)) u_pad (
        .clk        (clk),
        .rst        (rst),
        .load       (evt.done),
        .load_val   (load_val),
        .pad_active (pad_active),
        .pad_rem    (pad_rem)
    );

    assign busy_out = evt.active | (evt.done && (extra != '0)) | pad_active;

endmodule

// File: rtl/tx_throttle_chk.sv
module tx_throttle_chk #(
    parameter int PAD_W    = 24,
    parameter int FACTOR_W = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                gen_busy,
    input logic                gen_idle_gap,
    input logic                busy_out,
    input logic                in_frame,
    input logic [FACTOR_W-1:0] factor_q,
    input logic                pad_active,
    input logic [PAD_W-1:0]    pad_rem
);
    p_active_high_r2: assert property (@(posedge clk) disable iff (rst)
        (gen_busy || gen_idle_gap) |-> busy_out);

    p_pad_holds_r3: assert property (@(posedge clk) disable iff (rst)
        pad_active |-> busy_out);

    p_pad_descends_r3: assert property (@(posedge clk) disable iff (rst)
        (pad_active && $past(pad_active) && !$past(in_frame)) |-> (pad_rem < $past(pad_rem)));

    p_unity_no_pad_r4: assert property (@(posedge clk) disable iff (rst)
        (in_frame && !gen_busy && !gen_idle_gap && factor_q == '0) |-> !busy_out);

    p_ratio_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (in_frame && $past(in_frame)) |-> $stable(factor_q));

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(pad_active) && !gen_busy && !gen_idle_gap) |-> !busy_out);
endmodule

bind tx_throttle tx_throttle_chk #(.PAD_W(PAD_W), .FACTOR_W(tx_throttle_pkg::FACTOR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .gen_busy     (gen_busy),
    .gen_idle_gap (gen_idle_gap),
    .busy_out     (busy_out),
    .in_frame     (in_frame),
    .factor_q     (factor_q),
    .pad_active   (pad_active),
    .pad_rem      (pad_rem)
);

// File: tb/sim_tx_throttle.sv
`timescale 1ns/1ps
module sim_tx_throttle;
    localparam int HALF_NS = 10;
    localparam longint WDOG_NS = 64'd3800000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] link_speed = 3'b000;
    logic       gen_busy = 1'b0;
    logic       gen_idle_gap = 1'b0;
    logic       busy_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #HALF_NS clk = ~clk;

    tx_throttle u0 (
        .clk          (clk),
        .rst          (rst),
        .link_speed   (link_speed),
        .gen_busy     (gen_busy),
        .gen_idle_gap (gen_idle_gap),
        .busy_out     (busy_out)
    );

    function automatic int bench_ratio(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 10;
            4: return 100;
            5: return 1000;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step_sample();
        @(negedge clk);
        #1;
    endtask

    // mode 0: busy only, 1: busy then native idle gap, 2: idle gap only
    task automatic run_frame(input int code, input int n, input int mode,
                             input int new_code, input string tag);
        int expected = n * (bench_ratio(code) - 1);
        int cnt = 0;
        int low_seen = 0;
        bit bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            link_speed = (i > 0 && new_code >= 0) ? 3'(new_code) : 3'(code);
            case (mode)
                0: begin gen_busy = 1'b1; gen_idle_gap = 1'b0; end
                1: begin gen_busy = (i < (n + 1) / 2); gen_idle_gap = !(i < (n + 1) / 2); end
                default: begin gen_busy = 1'b0; gen_idle_gap = 1'b1; end
            endcase
            #1;
            if (!busy_out) bad = 1'b1;
        end
        check(!bad, {"R2 busy during activity ", tag}, longint'(!bad), 1);
        @(negedge clk);
        gen_busy = 1'b0;
        gen_idle_gap = 1'b0;
        #1;
        while (busy_out && cnt < 150000) begin
            cnt++;
            if (new_code >= 0) link_speed = 3'(new_code);
            step_sample();
        end
        check(cnt == expected, {"pad length ", tag}, cnt, expected);
        for (int k = 0; k < 2; k++) begin
            step_sample();
            if (!busy_out) low_seen++;
        end
        check(low_seen == 2, {"R6 stays low after pad ", tag}, low_seen, 2);
    endtask

    initial begin
        void'($urandom(32'd90210));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(busy_out == 1'b0, "R1 reset state", busy_out, 0);

        run_frame(0, 1, 0, -1, "R3 code000 n1");
        run_frame(1, 1, 0, -1, "R3 code001 n1");
        run_frame(2, 6, 1, -1, "R3 code010 mixed");
        run_frame(3, 12, 0, -1, "R3 code011");
        run_frame(4, 9, 1, -1, "R3 code100");
        run_frame(5, 4, 0, -1, "R3 code101");
        run_frame(6, 10, 0, -1, "R4 code110");
        run_frame(7, 3, 1, -1, "R4 code111");
        run_frame(2, 7, 2, -1, "R7 idle gap only");
        run_frame(4, 3, 0, 0, "R5 slow to fast");
        run_frame(0, 5, 0, 5, "R5 fast to slow");
        run_frame(3, 2, 0, -1, "R6 back to back a");
        run_frame(3, 2, 0, -1, "R6 back to back b");

        // Reset in the middle of padding
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            link_speed = 3'b011;
            gen_busy = 1'b1;
        end
        @(negedge clk);
        gen_busy = 1'b0;
        repeat (4) step_sample();
        check(busy_out == 1'b1, "R3 padding before reset", busy_out, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(busy_out == 1'b0, "R1 reset clears padding", busy_out, 0);
        step_sample();
        check(busy_out == 1'b0, "R1 stays low after reset", busy_out, 0);

        for (int f = 0; f < 30; f++) begin
            int code = $urandom_range(7, 0);
            int n = (code == 5) ? $urandom_range(6, 1) : $urandom_range(40, 1);
            int mode = $urandom_range(2, 0);
            int nc = ($urandom_range(3, 0) == 0) ? $urandom_range(7, 0) : -1;
            string tag;
            if (nc >= 0) tag = "R5 random";
            else if (code >= 6) tag = "R4 random";
            else if (mode == 2) tag = "R7 random";
            else tag = "R3 random";
            run_frame(code, n, mode, nc, tag);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(WDOG_NS);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule